// File: doc/BRIEF.md
# Parity-Banked Dual-Access Data Memory

This block gives two load/store request ports the appearance of one dual-ported data memory, although it is built from two single-port banks. Bit 0 of the word address picks the bank, so even words live in bank 0 and odd words in bank 1. When the two ports address different banks, both accesses are carried out in the same cycle. When they address the same bank, the block raises a stall, serves port 0 first and port 1 one cycle later. The requester holds its request inputs steady while the stall is high.

Each bank is split into sub-blocks of graded size. The smallest two hold `2^MIN_LOG` words each, and every further sub-block is twice the size of the one before it. The address, enable and write strobe reach only the sub-block that the address decodes to, so a short transform that uses only low addresses keeps the large sub-blocks quiet. With `BANK_AW = 13` and `MIN_LOG = 5`, each bank holds 8192 words in sub-blocks of 32, 32, 64, 128, 256, 512, 1024, 2048 and 4096 words. The default configuration is smaller and has the same structure.

Top module: `pbm_dualmem`

## Requirements
- R1: Bit 0 of the word address selects the bank (0 gives bank 0, 1 gives bank 1). Either port can write and read back each of the `2^(BANK_AW+1)` words.
- R2: A bank performs at most one access in any cycle.
- R3: If only one port requests, or the two ports request different banks, stall stays low and both accesses take effect in that cycle.
- R4: If both ports request the same bank, stall is high for exactly one cycle. Port 0 is served in that cycle and port 1 in the following cycle. The requester keeps its inputs unchanged while stall is high.
- R5: Only the addressed sub-block of a bank receives enable, write strobe and a non-zero address. Every other sub-block sees zero on all three.
- R6: The bank-internal address is a = word address >> 1. If a < 2^MIN_LOG, sub-block 0 is used. Otherwise sub-block p-MIN_LOG+1 is used, where p is the position of the highest set bit of a, and the offset within it is the low p bits. No two addresses alias.
- R7: Read data appears on the issuing port's rdata in the cycle after that port is served, and it stays there until that port's next read. A write does not change rdata.
- R8: If both ports write the same address in one cycle, the value from port 1 remains.
- R9: In a same-bank collision on one address, a read on port 1 returns the value port 0 writes, and a read on port 0 returns the value from before port 1's write.
- R10: After reset, both rdata outputs are zero and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p0_req | input | 1 | Port 0 access request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | BANK_AW+1 | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_rdata | output | DATA_W | Port 0 read data |
| p1_req | input | 1 | Port 1 access request |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | BANK_AW+1 | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_rdata | output | DATA_W | Port 1 read data |
| stall | output | 1 | High in the first cycle of a same-bank collision |

## Verification
The bench first fills every word through pairs of opposite parity, then reads every word back through pairs swapped between the ports. A bank decode that used a higher address bit would stall on these pairs, and a wrong sub-block offset would make the data at the sub-block boundaries (bank addresses 31/32, 63/64, 127/128) alias. Same-bank collisions come next: both ports reading, both writing one address, and a write paired with a read in both orders. These catch a stall that lasts more than one cycle, service done in the wrong order (so port 0's value wins or a read sees the wrong side of a write), and read data sent back to the other port or lost during the extra cycle. Finally the bench checks that a write-only access leaves each port's rdata unchanged.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

   // Number of graded sub-blocks in a bank of 2**bank_aw words whose
   // two smallest members hold 2**min_log words each.
   function automatic int unsigned pbm_nsub(input int unsigned bank_aw,
                                            input int unsigned min_log);
      return bank_aw - min_log + 1;
   endfunction

   // Offset width of sub-block k.
   function automatic int unsigned pbm_sub_aw(input int unsigned k,
                                              input int unsigned min_log);
      return (k == 0) ? min_log : min_log + k - 1;
   endfunction

endpackage

// File: rtl/pbm_subblock.sv
module pbm_subblock #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [LW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << LW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

   // A deselected sub-block must see quiet control and address lines.
   AST_IDLE_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!we && addr == '0)); // R5

endmodule

// File: rtl/pbm_bank.sv
module pbm_bank #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned BANK_AW = 8,
   parameter int unsigned MIN_LOG = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               we,
   input  logic [BANK_AW-1:0] addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata
);
   import pbm_pkg::*;

   localparam int unsigned NSUB  = pbm_nsub(BANK_AW, MIN_LOG);
   localparam int unsigned SEL_W = (NSUB > 1) ? $clog2(NSUB) : 1;

   if (BANK_AW <= MIN_LOG) begin : g_bad_geometry
      $error("pbm_bank: BANK_AW must exceed MIN_LOG");
   end
   if (DATA_W == 0) begin : g_bad_width
      $error("pbm_bank: DATA_W must be non-zero");
   end

   // Highest set bit at or above MIN_LOG picks the sub-block.
   function automatic logic [SEL_W-1:0] pick_sub(input logic [BANK_AW-1:0] a);
      logic [SEL_W-1:0] s;
      s = '0;
      for (int p = MIN_LOG; p < BANK_AW; p++) begin
         if (a[p]) s = SEL_W'(p - MIN_LOG + 1);
      end
      return s;
   endfunction

   logic [SEL_W-1:0]  sel;
   logic [NSUB-1:0]   sub_en;
   logic [DATA_W-1:0] sub_rd [NSUB];

   assign sel = pick_sub(addr);

   for (genvar k = 0; k < NSUB; k++) begin : g_sub
      localparam int unsigned LW = pbm_sub_aw(k, MIN_LOG);
      logic [LW-1:0] s_addr;
      logic          s_we;
      logic [DATA_W-1:0] s_wdata;

      assign sub_en[k] = en && (sel == SEL_W'(k));
      assign s_addr    = sub_en[k] ? addr[LW-1:0] : '0;
      assign s_we      = sub_en[k] && we;
      assign s_wdata   = sub_en[k] ? wdata : '0;

      pbm_subblock #(
         .DATA_W (DATA_W),
         .LW     (LW)
      ) u_sub (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (sub_en[k]),
         .we    (s_we),
         .addr  (s_addr),
         .wdata (s_wdata),
         .rdata (sub_rd[k])
      );
   end

   assign rdata = sub_rd[sel];

   AST_ONE_SUBBLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> $onehot(sub_en)); // R5
   AST_QUIET_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (sub_en == '0)); // R5

endmodule

// File: rtl/pbm_arbiter.sv
module pbm_arbiter (
   input  logic clk,
   input  logic rst_n,
   input  logic p0_req,
   input  logic p1_req,
   input  logic p0_bank,
   input  logic p1_bank,
   output logic stall,
   output logic serve0,
   output logic serve1
);
   logic collide;
   logic second_q;

   assign collide = p0_req && p1_req && (p0_bank == p1_bank);
   assign stall   = collide && !second_q;
   assign serve0  = p0_req && !second_q;
   assign serve1  = p1_req && (!collide || second_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) second_q <= 1'b0;
      else        second_q <= stall;
   end

   AST_SPLIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_req && p1_req && (p0_bank != p1_bank)) |-> !stall); // R3
   AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall); // R4
   AST_P0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (serve0 && !serve1)); // R4
   AST_P1_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (serve1 && !serve0)); // R4

endmodule

// File: rtl/pbm_dualmem.sv
module pbm_dualmem #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned BANK_AW = 8,
   parameter int unsigned MIN_LOG = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               p0_req,
   input  logic               p0_we,
   input  logic [BANK_AW:0]   p0_addr,
   input  logic [DATA_W-1:0]  p0_wdata,
   output logic [DATA_W-1:0]  p0_rdata,
   input  logic               p1_req,
   input  logic               p1_we,
   input  logic [BANK_AW:0]   p1_addr,
   input  logic [DATA_W-1:0]  p1_wdata,
   output logic [DATA_W-1:0]  p1_rdata,
   output logic               stall
);
   localparam int unsigned NBANK = 2;

   logic serve0, serve1;
   logic [DATA_W-1:0] bank_rd [NBANK];

   pbm_arbiter u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .p0_req  (p0_req),
      .p1_req  (p1_req),
      .p0_bank (p0_addr[0]),
      .p1_bank (p1_addr[0]),
      .stall   (stall),
      .serve0  (serve0),
      .serve1  (serve1)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic g0, g1;
      logic b_en, b_we;
      logic [BANK_AW-1:0] b_addr;
      logic [DATA_W-1:0]  b_wdata;

      assign g0 = serve0 && (p0_addr[0] == 1'(b));
      assign g1 = serve1 && (p1_addr[0] == 1'(b));

      always_comb begin
         b_en    = g0 || g1;
         b_we    = 1'b0;
         b_addr  = '0;
         b_wdata = '0;
         if (g1) begin
            b_we    = p1_we;
            b_addr  = p1_addr[BANK_AW:1];
            b_wdata = p1_wdata;
         end else if (g0) begin
            b_we    = p0_we;
            b_addr  = p0_addr[BANK_AW:1];
            b_wdata = p0_wdata;
         end
      end

      pbm_bank #(
         .DATA_W  (DATA_W),
         .BANK_AW (BANK_AW),
         .MIN_LOG (MIN_LOG)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (b_en),
         .we    (b_we),
         .addr  (b_addr),
         .wdata (b_wdata),
         .rdata (bank_rd[b])
      );

      AST_BANK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         !(g0 && g1)); // R2
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p0_rdata <= '0;
         p1_rdata <= '0;
      end else begin
         if (serve0 && !p0_we) p0_rdata <= bank_rd[p0_addr[0]];
         if (serve1 && !p1_we) p1_rdata <= bank_rd[p1_addr[0]];
      end
   end

   AST_RDATA_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
      !(serve0 && !p0_we) |=> $stable(p0_rdata)); // R7
   AST_RDATA_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
      !(serve1 && !p1_we) |=> $stable(p1_rdata)); // R7

endmodule

// File: tb/sim_pbm_dualmem.sv
module sim_pbm_dualmem;
   localparam int DW    = 32;
   localparam int BAW   = 8;
   localparam int WORDS = 1 << (BAW + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic p0_req = 0, p0_we = 0, p1_req = 0, p1_we = 0;
   logic [BAW:0] p0_addr = '0, p1_addr = '0;
   logic [DW-1:0] p0_wdata = '0, p1_wdata = '0;
   logic [DW-1:0] p0_rdata, p1_rdata;
   logic stall;

   int runs = 0;
   int fails = 0;
   logic [DW-1:0] model [WORDS];

   always #5 clk = ~clk;

   pbm_dualmem #(.DATA_W(DW), .BANK_AW(BAW), .MIN_LOG(5)) u0 (
      .clk(clk), .rst_n(rst_n),
      .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr),
      .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
      .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr),
      .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
      .stall(stall));

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return (DW'(a) * 32'h9E37_79B1) ^ DW'(salt);
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Starts shortly after a falling edge; ends shortly after a falling edge.
   task automatic access(input logic r0, input logic w0, input int a0,
                         input logic [DW-1:0] d0,
                         input logic r1, input logic w1, input int a1,
                         input logic [DW-1:0] d1, input string tag);
      logic coll;
      logic [DW-1:0] e0, e1, old0, old1;
      old0 = p0_rdata; old1 = p1_rdata;
      p0_req = r0; p0_we = w0; p0_addr = (BAW+1)'(a0); p0_wdata = d0;
      p1_req = r1; p1_we = w1; p1_addr = (BAW+1)'(a1); p1_wdata = d1;
      coll = r0 && r1 && (a0[0] == a1[0]);
      e0 = old0; e1 = old1;
      if (r0 && !w0) e0 = model[a0];
      if (r0 && w0)  model[a0] = d0;
      if (r1 && !w1) e1 = model[a1];
      if (r1 && w1)  model[a1] = d1;
      #1;
      chk(coll ? {tag, " R4 stall on same bank"} : {tag, " R3 no stall"},
          {31'd0, stall}, {31'd0, coll});
      @(posedge clk);
      if (coll) begin
         @(negedge clk); #1;
         chk({tag, " R4 stall drops after one cycle"}, {31'd0, stall}, 32'd0);
         @(posedge clk);
      end
      @(negedge clk); #1;
      p0_req = 0; p1_req = 0; p0_we = 0; p1_we = 0;
      if (tag != "") begin
         chk({tag, " port0 rdata"}, p0_rdata, e0);
         chk({tag, " port1 rdata"}, p1_rdata, e1);
      end else begin
         if (p0_rdata !== e0 || p1_rdata !== e1) begin
            chk("R1 R5 R6 sweep port0", p0_rdata, e0);
            chk("R1 R5 R6 sweep port1", p1_rdata, e1);
         end else runs++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R10 reset rdata0", p0_rdata, '0);
      chk("R10 reset rdata1", p1_rdata, '0);
      chk("R10 reset stall", {31'd0, stall}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R1 R3 R6: fill every word, even word on port 0, odd on port 1
      for (int k = 0; k < WORDS; k += 2)
         access(1, 1, k, pat(k, 1), 1, 1, k + 1, pat(k + 1, 1), "");
      // R1 R5 R6: read back every word, ports swapped across parity
      for (int k = 0; k < WORDS; k += 2)
         access(1, 0, k + 1, '0, 1, 0, k, '0, "");
      // R7: single-port reads then write-only access leaves rdata alone
      access(1, 0, 64, '0, 0, 0, 0, '0, "R3 R7 single read p0");
      access(0, 0, 0, '0, 1, 0, 257, '0, "R3 R7 single read p1");
      access(1, 1, 130, 32'h1111_2222, 1, 1, 131, 32'h3333_4444,
             "R7 write keeps rdata");
      // R4: both read bank 0 at sub-block boundaries
      access(1, 0, 62, '0, 1, 0, 64, '0, "R4 R6 dual read bank0");
      access(1, 0, 255, '0, 1, 0, 511, '0, "R4 R6 dual read bank1");
      // R8: both write same address
      access(1, 1, 200, 32'hAAAA_0000, 1, 1, 200, 32'hBBBB_0001,
             "R8 same-address write");
      access(1, 0, 200, '0, 0, 0, 0, '0, "R8 readback");
      // R9: p0 writes, p1 reads same address
      access(1, 1, 77, 32'hC0DE_0077, 1, 0, 77, '0, "R9 write then read");
      // R9: p0 reads, p1 writes same address
      access(1, 0, 300, '0, 1, 1, 300, 32'hFACE_0300, "R9 read then write");
      access(0, 0, 0, '0, 1, 0, 300, '0, "R9 readback");
      // R2 R4: collision with mixed read and write on different addresses
      access(1, 0, 3, '0, 1, 1, 129, 32'h0123_4567, "R2 R4 mixed collision");
      // final full reread to catch disturbance of other words
      for (int k = 0; k < WORDS; k += 2)
         access(1, 0, k, '0, 1, 0, k + 1, '0, "");

      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end
endmodule